// File: doc/BRIEF.md
# Dual-Channel Converter Serial Target Controller

This block is the two-wire serial target (slave) for a dual-channel converter. It oversamples the bus clock and data lines on a fast system clock and recognises start, repeated start and stop conditions. It then answers one 7-bit target address and acknowledges each byte it accepts. A write carries three bytes after the address: a channel-select byte, the upper data byte and the lower data byte. After the last byte is acknowledged, the controller hands the full 16-bit word and the channel selection to a neighbouring register bank in a single strobe.

For reads, the controller drives the stored channel selection out to the register bank and takes back the 16-bit contents of that channel. It shifts this word out as two bytes. The channel selection persists between transactions, so a master may read with nothing but an address byte. A master that acknowledges the second byte receives the same pair again. The bus data line is driven only as an open-drain pull-down enable.

Top module: `dac_i2c_target`

## Requirements
- R1: The target answers address {6'b000110, addr_strap} (address bits 7:1, R/W in bit 0, 1 = read) by pulling SDA low during the ninth clock. Any other address is not acknowledged, and the target stays silent until the next start.
- R2: A write of address(W), select byte, upper byte and lower byte gives exactly one wr_strobe pulse, one clock wide, after the lower byte's acknowledge clock ends. wr_word = {upper, lower} and wr_sel = select bits [1:0] are valid in the same cycle.
- R3: Select bit 0 chooses channel A and bit 1 chooses channel B, and both may be set together. Bits 7:2 of the select byte are ignored. The stored selection appears on ptr_sel, is kept across transactions, and is 2'b00 after reset.
- R4: After an acknowledged read address, the target sends the upper byte and then the lower byte of the readback word, most significant bit first. SDA changes only while SCL is low.
- R5: A read made of only the address with R/W = 1 returns data for the selection stored by an earlier transaction.
- R6: If the master acknowledges the lower byte, the target sends the upper and lower bytes again.
- R7: With selection 2'b00 or 2'b11 the returned word is 16'h2000, whatever rd_word holds.
- R8: Bits below the data field (the low 12 - DATA_BITS bits; bits 1:0 at DATA_BITS = 10) read back as 0.
- R9: A master not-acknowledge on a read byte makes the target release SDA, and it stays released until the stop.
- R10: A stop or a repeated start before the lower byte's acknowledge produces no strobe. A select byte that was already acknowledged stays stored.
- R11: After reset, sda_oe and wr_strobe are 0 and ptr_sel is 2'b00.
- R12: sda_oe changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Strap giving the lowest address bit |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| ptr_sel | output | 2 | Stored channel selection (bit 0 A, bit 1 B) |
| rd_word | input | 16 | Register bank contents for the channel on ptr_sel |
| wr_strobe | output | 1 | One-cycle pulse when a full write arrives |
| wr_sel | output | 2 | Channel selection belonging to wr_word |
| wr_word | output | 16 | Received 16-bit data word |

## Verification
Each line passes through two synchroniser flops and one edge-history flop, and the controller reacts one clock after that. As a result, sda_oe and wr_strobe change three clock cycles after the SCL pin falls. The bench drives SCL with a 20-cycle half period. It reads SDA in the middle of the high phase and the strobe monitor works on the falling clock edge, so every result is sampled well after that three-cycle delay and well before the next bus edge. Writes are queued as expected strobes and reads as expected bytes. The monitor and the byte receiver take their expected values from these queues, and a strobe arriving with an empty queue counts as a failure.

// File: rtl/dac_i2c_pkg.sv
// Shared constants and types for the dual-channel converter serial target.
// Assumes a 16-bit transfer word split into two bytes, upper byte first.
package dac_i2c_pkg;
    localparam logic [5:0]  ADDR_UPPER  = 6'b000110;
    localparam logic [15:0] IDLE_WORD   = 16'h2000;
    localparam int          WORD_W      = 16;
    localparam int          CTRL_BITS   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } eng_state_t;
endpackage

// File: rtl/dac_i2c_sync.sv
// Bus line conditioner: synchronises SCL and SDA into the clk domain
// and derives clock edges plus start and stop conditions.
// Assumes SCL/SDA idle high and are slow compared with clk.
module dac_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_raw, scl_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Purpose: shift one line through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    // Purpose: keep the previous synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign bus_start = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign bus_stop  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/dac_i2c_readfmt.sv
// Readback formatter: substitutes the idle word when no single channel
// is selected and clears the padding bits below the data field.
// Assumes the bank returns the word for the channel on sel.
module dac_i2c_readfmt
    import dac_i2c_pkg::*;
#(
    parameter int DATA_BITS = 10
) (
    input  logic [1:0]        sel,
    input  logic [WORD_W-1:0] bank_word,
    output logic [WORD_W-1:0] fmt_word
);
    localparam int PAD = WORD_W - CTRL_BITS - DATA_BITS;
    localparam logic [WORD_W-1:0] KEEP = ~((WORD_W'(1) << PAD) - WORD_W'(1));

    // Purpose: pick bank data for a single channel, else the idle word.
    always_comb begin
        if (sel == 2'b01 || sel == 2'b10) fmt_word = bank_word & KEEP;
        else                              fmt_word = IDLE_WORD;
    end
endmodule

// File: rtl/dac_i2c_engine.sv
// Protocol engine: address match, byte acknowledge, select byte storage,
// write word assembly and two-byte readback with repeat on master ACK.
// Assumes conditioned bus events from dac_i2c_sync; SDA updated only
// after an SCL falling edge has been seen.
module dac_i2c_engine
    import dac_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              addr_strap,
    input  logic [WORD_W-1:0] rd_fmt,
    output logic              sda_oe,
    output logic [1:0]        ptr_sel,
    output logic              wr_strobe,
    output logic [1:0]        wr_sel,
    output logic [WORD_W-1:0] wr_word
);
    eng_state_t state;
    logic [3:0] bit_cnt;
    logic [1:0] byte_idx;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic [7:0] lo_hold;
    logic [7:0] upper_q;
    logic [7:0] lower_q;
    logic       rw_q;
    logic       lo_next;
    logic       mack;

    // Purpose: bus protocol sequencing and all engine registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            byte_idx  <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            lo_hold   <= '0;
            upper_q   <= '0;
            lower_q   <= '0;
            rw_q      <= 1'b0;
            lo_next   <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            ptr_sel   <= 2'b00;
            wr_strobe <= 1'b0;
            wr_sel    <= 2'b00;
            wr_word   <= '0;
        end else begin
            wr_strobe <= 1'b0;
            if (bus_start) begin
                state    <= ST_RX;
                bit_cnt  <= '0;
                byte_idx <= '0;
                sda_oe   <= 1'b0;
            end else if (bus_stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (byte_idx == 2'd0) begin
                                if (rx_sh[7:1] == {ADDR_UPPER, addr_strap}) begin
                                    rw_q   <= rx_sh[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                if (byte_idx == 2'd1)      ptr_sel <= rx_sh[1:0];
                                else if (byte_idx == 2'd2) upper_q <= rx_sh;
                                else                       lower_q <= rx_sh;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (byte_idx == 2'd0 && rw_q) begin
                                tx_sh   <= rd_fmt[15:8];
                                lo_hold <= rd_fmt[7:0];
                                sda_oe  <= ~rd_fmt[15];
                                lo_next <= 1'b1;
                                state   <= ST_TX;
                            end else if (byte_idx == 2'd3) begin
                                wr_strobe <= 1'b1;
                                wr_word   <= {upper_q, lower_q};
                                wr_sel    <= ptr_sel;
                                sda_oe    <= 1'b0;
                                state     <= ST_IDLE;
                            end else begin
                                byte_idx <= byte_idx + 2'd1;
                                sda_oe   <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                tx_sh   <= {tx_sh[6:0], 1'b0};
                                sda_oe  <= ~tx_sh[6];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                bit_cnt <= '0;
                                state   <= ST_TX;
                                if (lo_next) begin
                                    tx_sh   <= lo_hold;
                                    sda_oe  <= ~lo_hold[7];
                                    lo_next <= 1'b0;
                                end else begin
                                    tx_sh   <= rd_fmt[15:8];
                                    lo_hold <= rd_fmt[7:0];
                                    sda_oe  <= ~rd_fmt[15];
                                    lo_next <= 1'b1;
                                end
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R2: the write strobe lasts exactly one cycle.
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    // R2: the write strobe follows the end of an acknowledge clock.
    p_strobe_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(scl_fall));

    // R12: the data line enable moves only in the SCL low phase.
    p_sda_low_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_s) == 1'b0));

    // R9: an idle engine never pulls the data line.
    p_idle_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R3: the stored selection changes only at an SCL falling edge.
    p_ptr_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_sel != $past(ptr_sel)) |-> $past(scl_fall));
endmodule

// File: rtl/dac_i2c_target.sv
// Top of the dual-channel converter serial target: line conditioner,
// protocol engine and readback formatter.
// Assumes clk is at least ~20x the SCL rate and SDA is open drain.
module dac_i2c_target
    import dac_i2c_pkg::*;
#(
    parameter int DATA_BITS   = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_strap,
    output logic              sda_oe,
    output logic [1:0]        ptr_sel,
    input  logic [WORD_W-1:0] rd_word,
    output logic              wr_strobe,
    output logic [1:0]        wr_sel,
    output logic [WORD_W-1:0] wr_word
);
    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [WORD_W-1:0] rd_fmt;

    dac_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_i),
        .sda_raw   (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    dac_i2c_readfmt #(.DATA_BITS(DATA_BITS)) u_fmt (
        .sel       (ptr_sel),
        .bank_word (rd_word),
        .fmt_word  (rd_fmt)
    );

    dac_i2c_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_s      (scl_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .addr_strap (addr_strap),
        .rd_fmt     (rd_fmt),
        .sda_oe     (sda_oe),
        .ptr_sel    (ptr_sel),
        .wr_strobe  (wr_strobe),
        .wr_sel     (wr_sel),
        .wr_word    (wr_word)
    );
endmodule

// File: tb/dac_i2c_target_bench.sv
// Scoreboard bench: driver tasks queue expected strobes and read bytes,
// a monitor and the byte receiver compare against the queues.
module dac_i2c_target_bench;
    localparam int DATA_BITS = 10;
    localparam logic [15:0] KEEP = ~((16'h1 << (12 - DATA_BITS)) - 16'h1);
    localparam logic [15:0] BANK_A = 16'hC3FF;
    localparam logic [15:0] BANK_B = 16'h5A67;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_pin = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b1;
    logic sda_oe;
    logic [1:0] ptr_sel;
    logic [15:0] rd_word;
    logic wr_strobe;
    logic [1:0] wr_sel;
    logic [15:0] wr_word;
    logic sda_line;

    int n_checks = 0;
    int n_fail = 0;
    int r12_viol = 0;
    bit done = 1'b0;
    logic [17:0] exp_wr[$];
    logic [7:0]  exp_rd[$];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_word  = (ptr_sel == 2'b01) ? BANK_A :
                      (ptr_sel == 2'b10) ? BANK_B : 16'hFFFF;

    dac_i2c_target #(.DATA_BITS(DATA_BITS)) u_dac_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_pin), .sda_i(sda_line),
        .addr_strap(strap), .sda_oe(sda_oe), .ptr_sel(ptr_sel),
        .rd_word(rd_word), .wr_strobe(wr_strobe), .wr_sel(wr_sel),
        .wr_word(wr_word)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; tick(5); scl_pin = 1'b1; tick(10);
        sda_m = 1'b0; tick(10); scl_pin = 1'b0; tick(5);
    endtask

    task automatic do_stop();
        tick(5); sda_m = 1'b0; tick(10); scl_pin = 1'b1; tick(10);
        sda_m = 1'b1; tick(20);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            tick(5); sda_m = b[i]; tick(10);
            scl_pin = 1'b1; tick(20); scl_pin = 1'b0; tick(5);
        end
        tick(5); sda_m = 1'b1; tick(10); scl_pin = 1'b1; tick(10);
        acked = (sda_line == 1'b0);
        tick(10); scl_pin = 1'b0; tick(5);
    endtask

    task automatic recv_byte(input bit ack_it, input string req);
        logic [7:0] b;
        logic [7:0] e;
        for (int i = 7; i >= 0; i--) begin
            tick(5); sda_m = 1'b1; tick(10); scl_pin = 1'b1; tick(10);
            b[i] = sda_line; tick(10); scl_pin = 1'b0; tick(5);
        end
        e = (exp_rd.size() > 0) ? exp_rd.pop_front() : 8'hXX;
        check(b === e, req, 32'(b), 32'(e));
        tick(5); sda_m = ack_it ? 1'b0 : 1'b1; tick(10);
        scl_pin = 1'b1; tick(20); scl_pin = 1'b0; tick(5);
    endtask

    // Full write with expected strobe queued.
    task automatic do_write(input logic [7:0] ptr, input logic [7:0] hi,
                            input logic [7:0] lo);
        bit a;
        exp_wr.push_back({ptr[1:0], hi, lo});
        do_start();
        send_byte({6'b000110, strap, 1'b0}, a); check(a, "R1 address ack", 32'(a), 1);
        send_byte(ptr, a); check(a, "R2 select ack", 32'(a), 1);
        send_byte(hi, a);  check(a, "R2 upper ack", 32'(a), 1);
        send_byte(lo, a);  check(a, "R2 lower ack", 32'(a), 1);
        do_stop();
        tick(10);
    endtask

    task automatic set_ptr(input logic [7:0] ptr);
        bit a;
        do_start();
        send_byte({6'b000110, strap, 1'b0}, a); check(a, "R1 address ack", 32'(a), 1);
        send_byte(ptr, a); check(a, "R3 select ack", 32'(a), 1);
        do_stop();
        tick(10);
    endtask

    task automatic push_word(input logic [15:0] w);
        exp_rd.push_back(w[15:8]);
        exp_rd.push_back(w[7:0]);
    endtask

    // Monitor: compare every strobe against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && wr_strobe) begin
            if (exp_wr.size() == 0) begin
                check(1'b0, "R10 unexpected strobe", 32'({wr_sel, wr_word}), 0);
            end else begin
                logic [17:0] e;
                e = exp_wr.pop_front();
                check({wr_sel, wr_word} == e, "R2 strobe data", 32'({wr_sel, wr_word}), 32'(e));
            end
        end
    end

    // Monitor: record any enable change while the SCL pin is high.
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_pin && sda_oe != oe_prev) r12_viol++;
        oe_prev <= sda_oe;
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        bit a;
        tick(5);
        // R11: reset state
        check(sda_oe == 1'b0, "R11 sda_oe reset", 32'(sda_oe), 0);
        check(wr_strobe == 1'b0, "R11 strobe reset", 32'(wr_strobe), 0);
        check(ptr_sel == 2'b00, "R11 ptr reset", 32'(ptr_sel), 0);
        rst_n = 1'b1;
        tick(20);

        // R7: read with reset selection (00) returns idle word
        push_word(16'h2000);
        do_start();
        send_byte({6'b000110, strap, 1'b1}, a); check(a, "R1 read address ack", 32'(a), 1);
        recv_byte(1'b1, "R7 idle upper"); recv_byte(1'b0, "R7 idle lower");
        do_stop();

        // R2/R3: write channel A
        do_write(8'h01, 8'hC5, 8'h3A);
        check(ptr_sel == 2'b01, "R3 ptr A", 32'(ptr_sel), 1);

        // R1: wrong address not acknowledged, no strobe
        do_start();
        send_byte({6'b000110, ~strap, 1'b0}, a); check(!a, "R1 mismatch nack", 32'(a), 0);
        send_byte(8'h02, a); check(!a, "R1 silent after mismatch", 32'(a), 0);
        do_stop();
        check(ptr_sel == 2'b01, "R1 ptr unchanged", 32'(ptr_sel), 1);

        // R1: strap = 0 changes the answered address
        strap = 1'b0;
        do_write(8'hFE, 8'h12, 8'h34);
        // R3: upper select bits ignored
        check(ptr_sel == 2'b10, "R3 upper bits ignored", 32'(ptr_sel), 2);
        do_write(8'h03, 8'hA5, 8'h5A);
        check(ptr_sel == 2'b11, "R3 both channels", 32'(ptr_sel), 3);

        // R4/R8: select B then repeated start read, NACK ends (R9)
        push_word(BANK_B & KEEP);
        do_start();
        send_byte({6'b000110, strap, 1'b0}, a); check(a, "R4 address ack", 32'(a), 1);
        send_byte(8'h02, a); check(a, "R4 select ack", 32'(a), 1);
        do_start();
        send_byte({6'b000110, strap, 1'b1}, a); check(a, "R4 read address ack", 32'(a), 1);
        recv_byte(1'b1, "R4 upper B"); recv_byte(1'b0, "R8 lower B padding");
        tick(3);
        check(sda_oe == 1'b0, "R9 released after nack", 32'(sda_oe), 0);
        do_stop();

        // R5/R6: address-only read reuses B, master ACK repeats the pair
        push_word(BANK_B & KEEP); push_word(BANK_B & KEEP);
        do_start();
        send_byte({6'b000110, strap, 1'b1}, a); check(a, "R5 read address ack", 32'(a), 1);
        recv_byte(1'b1, "R5 upper"); recv_byte(1'b1, "R5 lower");
        recv_byte(1'b1, "R6 repeat upper"); recv_byte(1'b0, "R6 repeat lower");
        do_stop();

        // R8: channel A with padding bits set in the bank
        set_ptr(8'h01);
        push_word(BANK_A & KEEP);
        do_start();
        send_byte({6'b000110, strap, 1'b1}, a); check(a, "R8 read address ack", 32'(a), 1);
        recv_byte(1'b1, "R8 upper A"); recv_byte(1'b0, "R8 lower A padding");
        do_stop();

        // R7: both channels selected returns idle word
        set_ptr(8'h03);
        push_word(16'h2000);
        do_start();
        send_byte({6'b000110, strap, 1'b1}, a); check(a, "R7 read address ack", 32'(a), 1);
        recv_byte(1'b1, "R7 both upper"); recv_byte(1'b0, "R7 both lower");
        do_stop();

        // R10: stop after upper byte, then repeated start after upper byte
        do_start();
        send_byte({6'b000110, strap, 1'b0}, a);
        send_byte(8'h02, a);
        send_byte(8'h77, a); check(a, "R10 upper ack", 32'(a), 1);
        do_stop();
        check(ptr_sel == 2'b10, "R10 acked select kept", 32'(ptr_sel), 2);
        do_start();
        send_byte({6'b000110, strap, 1'b0}, a);
        send_byte(8'h01, a);
        send_byte(8'h66, a);
        do_start();
        send_byte({6'b000110, strap, 1'b1}, a);
        push_word(BANK_A & KEEP);
        recv_byte(1'b1, "R10 read after abort"); recv_byte(1'b0, "R10 read after abort lower");
        do_stop();
        tick(20);

        check(exp_wr.size() == 0, "R2 all strobes seen", 32'(exp_wr.size()), 0);
        check(r12_viol == 0, "R12 sda change while scl high", 32'(r12_viol), 0);
        done = 1'b1;
        finish_run();
    end
endmodule